// File: doc/BRIEF.md
# Flattened Butterfly Adaptive Route Unit

This block makes the routing decision for one router of a two-dimensional flattened-butterfly on-chip network. The router serves several local terminals and has one direct link to every other router in its row and every other router in its column. So each dimension is crossed in a single hop, and a minimal route between two routers needs at most two inter-router hops. The block accepts one head flit per handshake. The flit carries the destination router coordinates, the destination terminal, and the packet's routing state. The block also receives queue occupancy estimates for its inter-router output ports. It returns the output port, the virtual channel class and the intermediate router the packet is bound for.

When a packet enters the network at this router, the block weighs two paths. The first is the minimal path. The second is a non-minimal path through an intermediate router, drawn from a free-running pseudo-random source. The block takes the non-minimal path only when it looks cheaper under a load-times-distance measure. Both paths move along X first and then along Y. Two virtual channel classes keep the network free of deadlock: class 0 carries a packet toward its intermediate router, and class 1 carries it toward its destination. At transit routers the block follows the routing state carried in the flit and switches a packet from class 0 to class 1 once the packet reaches its intermediate router.

Top module: `fbfly_route_unit`

## Requirements
- R1: Output port encoding. Terminal t maps to port t (0..3). The row link toward column x maps to port 4+r, and the column link toward row y maps to port 7+r. Here r is the target coordinate if it is below this router's own coordinate, and the target coordinate minus one otherwise.
- R2: Every hop follows X before Y. A packet whose X differs leaves on the row link toward the target X. When only Y differs, it leaves on the column link toward the target Y. At the target router it leaves on the terminal port given by the destination terminal index.
- R3: For a newly injected packet whose destination is another router, the non-minimal path is chosen exactly when q_min*h_min > q_non*h_non (strict). Here q is the occupancy of that path's first-hop port, taken from occ_i bits [6*(p-4) +: 6] for port p. h_min is the minimal hop count, and h_non is the hop count from this router to the intermediate router plus the hop count from the intermediate router to the destination.
- R4: For a newly injected packet, the reported intermediate router is never this router and never the destination router.
- R5: VC class, encoded as 0 = toward intermediate and 1 = toward destination. A new packet routed non-minimally leaves on class 0, with rsp_nonmin_o=1. A new packet routed minimally leaves on class 1, with rsp_nonmin_o=0.
- R6: A transit packet on class 0 routes toward its carried intermediate router on class 0, with nonmin=1. Once it sits at that router, it routes toward the destination on class 1, with nonmin=0. A transit packet on class 1 routes toward the destination on class 1. A transit response echoes the carried intermediate coordinates.
- R7: A new packet whose destination is this router is ejected on its terminal port on class 1, with nonmin=0, regardless of occupancy.
- R8: The decision appears on the response outputs in the cycle after the request is accepted (req_valid_i && req_ready_o).
- R9: While rsp_valid_o=1 and rsp_ready_i=0, req_ready_o=0 and all response outputs hold.
- R10: After reset, rsp_valid_o=0 and req_ready_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| my_x_i | input | 2 | This router's X coordinate |
| my_y_i | input | 2 | This router's Y coordinate |
| occ_i | input | 36 | Occupancy of the six inter-router ports, 6 bits each, port 4 lowest |
| req_valid_i | input | 1 | Head flit request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_new_i | input | 1 | Packet injected at this router |
| req_vc_i | input | 1 | Current VC class of a transit packet |
| req_mid_x_i | input | 2 | Carried intermediate X of a transit packet |
| req_mid_y_i | input | 2 | Carried intermediate Y of a transit packet |
| req_dst_x_i | input | 2 | Destination router X |
| req_dst_y_i | input | 2 | Destination router Y |
| req_dst_term_i | input | 2 | Destination terminal index |
| rsp_valid_o | output | 1 | Decision valid |
| rsp_ready_i | input | 1 | Decision consumed |
| rsp_port_o | output | 4 | Chosen output port |
| rsp_vc_o | output | 1 | Chosen VC class |
| rsp_nonmin_o | output | 1 | Packet is on a non-minimal leg |
| rsp_mid_x_o | output | 2 | Intermediate router X |
| rsp_mid_y_o | output | 2 | Intermediate router Y |

## Verification
The strict comparison is probed with occupancies that make both costs equal. A design using greater-or-equal would then detour packets that should go minimally. Some cases put the intermediate router in the minimal path's own row or column, so both paths share their first-hop port. A wrong hop count for either leg then flips the choice. Other cases check that the intermediate router is never this router or the destination, that a local destination ejects even under heavy load, and that a class-0 transit packet arriving at its intermediate router turns onto class 1 and heads to the destination. A back-pressure case checks that a decision held under stall does not change and that no second request slips in.

// File: rtl/fbfly_route_pkg.sv
package fbfly_route_pkg;
  typedef enum logic {
    VC_TO_MID = 1'b0,
    VC_TO_DST = 1'b1
  } vc_e;

  localparam logic [3:0] LFSR_TAPS_4 = 4'b1100;
  localparam logic [3:0] LFSR_SEED_4 = 4'b0001;
endpackage

// File: rtl/fbfly_lfsr.sv
module fbfly_lfsr #(
  parameter int unsigned W = 4,
  parameter logic [W-1:0] TAPS = W'(4'b1100),
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= {state_q[W-2:0], ^(state_q & TAPS)};
  end

  assign state_o = state_q;

  // zero state would lock the generator
  p_lfsr_nonzero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q != '0);
endmodule

// File: rtl/fbfly_mid_pick.sv
module fbfly_mid_pick #(
  parameter int unsigned XW = 2,
  parameter int unsigned YW = 2,
  parameter int unsigned TRIES = 3,
  localparam int unsigned CW = XW + YW
) (
  input  logic [CW-1:0] rand_i,
  input  logic [XW-1:0] my_x_i,
  input  logic [YW-1:0] my_y_i,
  input  logic [XW-1:0] dst_x_i,
  input  logic [YW-1:0] dst_y_i,
  output logic [XW-1:0] mid_x_o,
  output logic [YW-1:0] mid_y_o
);
  logic [CW-1:0] cand [TRIES];
  logic [TRIES-1:0] ok;
  logic [CW-1:0] me, dst;

  assign me  = {my_y_i, my_x_i};
  assign dst = {dst_y_i, dst_x_i};

  // at most two values are excluded, so three consecutive candidates suffice
  for (genvar k = 0; k < TRIES; k++) begin : g_cand
    assign cand[k] = rand_i + CW'(k);
    assign ok[k]   = (cand[k] != me) && (cand[k] != dst);
  end

  always_comb begin
    logic [CW-1:0] sel;
    sel = cand[TRIES-1];
    for (int k = TRIES - 2; k >= 0; k--) begin
      if (ok[k]) sel = cand[k];
    end
    mid_x_o = sel[XW-1:0];
    mid_y_o = sel[CW-1:XW];
  end
endmodule

// File: rtl/fbfly_dor_hop.sv
module fbfly_dor_hop #(
  parameter int unsigned CONC   = 4,
  parameter int unsigned GRID_X = 4,
  parameter int unsigned XW     = 2,
  parameter int unsigned YW     = 2,
  parameter int unsigned TW     = 2,
  parameter int unsigned PW     = 4
) (
  input  logic [XW-1:0] from_x_i,
  input  logic [YW-1:0] from_y_i,
  input  logic [XW-1:0] to_x_i,
  input  logic [YW-1:0] to_y_i,
  input  logic [TW-1:0] term_i,
  output logic [PW-1:0] port_o,
  output logic [1:0]    hops_o
);
  localparam int unsigned ROW_BASE = CONC;
  localparam int unsigned COL_BASE = CONC + GRID_X - 1;

  logic dx, dy;
  assign dx = (from_x_i != to_x_i);
  assign dy = (from_y_i != to_y_i);
  assign hops_o = {1'b0, dx} + {1'b0, dy};

  always_comb begin
    int p;
    if (dx) begin
      p = ROW_BASE + ((to_x_i < from_x_i) ? int'(to_x_i) : int'(to_x_i) - 1);
    end else if (dy) begin
      p = COL_BASE + ((to_y_i < from_y_i) ? int'(to_y_i) : int'(to_y_i) - 1);
    end else begin
      p = int'(term_i);
    end
    port_o = PW'(p);
  end
endmodule

// File: rtl/fbfly_route_unit.sv
module fbfly_route_unit
  import fbfly_route_pkg::*;
#(
  parameter int unsigned CONC   = 4,
  parameter int unsigned GRID_X = 4,
  parameter int unsigned GRID_Y = 4,
  parameter int unsigned QW     = 6,
  localparam int unsigned XW    = $clog2(GRID_X),
  localparam int unsigned YW    = $clog2(GRID_Y),
  localparam int unsigned TW    = $clog2(CONC),
  localparam int unsigned NET   = GRID_X + GRID_Y - 2,
  localparam int unsigned RADIX = CONC + NET,
  localparam int unsigned PW    = $clog2(RADIX),
  localparam int unsigned CSTW  = QW + 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [XW-1:0]    my_x_i,
  input  logic [YW-1:0]    my_y_i,
  input  logic [NET*QW-1:0] occ_i,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_new_i,
  input  logic             req_vc_i,
  input  logic [XW-1:0]    req_mid_x_i,
  input  logic [YW-1:0]    req_mid_y_i,
  input  logic [XW-1:0]    req_dst_x_i,
  input  logic [YW-1:0]    req_dst_y_i,
  input  logic [TW-1:0]    req_dst_term_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PW-1:0]    rsp_port_o,
  output logic             rsp_vc_o,
  output logic             rsp_nonmin_o,
  output logic [XW-1:0]    rsp_mid_x_o,
  output logic [YW-1:0]    rsp_mid_y_o
);
  logic [XW+YW-1:0] rand_w;
  logic [XW-1:0]    pick_x, mid_x;
  logic [YW-1:0]    pick_y, mid_y;
  logic [PW-1:0]    port_min, port_mid, port_unused;
  logic [1:0]       hops_min, hops_mid, hops_m2d;
  logic             at_dst, at_mid, accept;

  fbfly_lfsr #(.W(XW + YW), .TAPS(LFSR_TAPS_4), .SEED(LFSR_SEED_4)) u_lfsr (
    .clk_i, .rst_ni, .state_o(rand_w)
  );

  fbfly_mid_pick #(.XW(XW), .YW(YW)) u_pick (
    .rand_i(rand_w), .my_x_i, .my_y_i,
    .dst_x_i(req_dst_x_i), .dst_y_i(req_dst_y_i),
    .mid_x_o(pick_x), .mid_y_o(pick_y)
  );

  assign mid_x = req_new_i ? pick_x : req_mid_x_i;
  assign mid_y = req_new_i ? pick_y : req_mid_y_i;

  fbfly_dor_hop #(.CONC(CONC), .GRID_X(GRID_X), .XW(XW), .YW(YW), .TW(TW), .PW(PW)) u_hop_min (
    .from_x_i(my_x_i), .from_y_i(my_y_i), .to_x_i(req_dst_x_i), .to_y_i(req_dst_y_i),
    .term_i(req_dst_term_i), .port_o(port_min), .hops_o(hops_min)
  );

  fbfly_dor_hop #(.CONC(CONC), .GRID_X(GRID_X), .XW(XW), .YW(YW), .TW(TW), .PW(PW)) u_hop_mid (
    .from_x_i(my_x_i), .from_y_i(my_y_i), .to_x_i(mid_x), .to_y_i(mid_y),
    .term_i(req_dst_term_i), .port_o(port_mid), .hops_o(hops_mid)
  );

  fbfly_dor_hop #(.CONC(CONC), .GRID_X(GRID_X), .XW(XW), .YW(YW), .TW(TW), .PW(PW)) u_hop_m2d (
    .from_x_i(mid_x), .from_y_i(mid_y), .to_x_i(req_dst_x_i), .to_y_i(req_dst_y_i),
    .term_i(req_dst_term_i), .port_o(port_unused), .hops_o(hops_m2d)
  );

  assign at_dst = (my_x_i == req_dst_x_i) && (my_y_i == req_dst_y_i);
  assign at_mid = (my_x_i == req_mid_x_i) && (my_y_i == req_mid_y_i);

  // occupancy of the first-hop port of each candidate path
  logic [QW-1:0] q_min, q_non;
  always_comb begin
    q_min = '0;
    q_non = '0;
    for (int k = 0; k < NET; k++) begin
      if (int'(port_min) == CONC + k) q_min = occ_i[k*QW +: QW];
      if (int'(port_mid) == CONC + k) q_non = occ_i[k*QW +: QW];
    end
  end

  logic [CSTW-1:0] cost_min, cost_non;
  logic [2:0]      h_non;
  logic            go_nonmin;
  assign h_non    = {1'b0, hops_mid} + {1'b0, hops_m2d};
  assign cost_min = CSTW'(q_min) * CSTW'(hops_min);
  assign cost_non = CSTW'(q_non) * CSTW'(h_non);
  assign go_nonmin = !at_dst && (cost_min > cost_non);

  logic [PW-1:0] nx_port;
  vc_e           nx_vc;
  logic          nx_nonmin;
  always_comb begin
    nx_port   = port_min;
    nx_vc     = VC_TO_DST;
    nx_nonmin = 1'b0;
    if (req_new_i) begin
      if (go_nonmin) begin
        nx_port   = port_mid;
        nx_vc     = VC_TO_MID;
        nx_nonmin = 1'b1;
      end
    end else if (req_vc_i == VC_TO_MID && !at_mid) begin
      nx_port   = port_mid;
      nx_vc     = VC_TO_MID;
      nx_nonmin = 1'b1;
    end
  end

  logic          rsp_valid_q, rsp_nonmin_q;
  logic [PW-1:0] rsp_port_q;
  vc_e           rsp_vc_q;
  logic [XW-1:0] rsp_mid_x_q;
  logic [YW-1:0] rsp_mid_y_q;

  assign req_ready_o = !rsp_valid_q || rsp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q  <= 1'b0;
      rsp_port_q   <= '0;
      rsp_vc_q     <= VC_TO_DST;
      rsp_nonmin_q <= 1'b0;
      rsp_mid_x_q  <= '0;
      rsp_mid_y_q  <= '0;
    end else if (accept) begin
      rsp_valid_q  <= 1'b1;
      rsp_port_q   <= nx_port;
      rsp_vc_q     <= nx_vc;
      rsp_nonmin_q <= nx_nonmin;
      rsp_mid_x_q  <= mid_x;
      rsp_mid_y_q  <= mid_y;
    end else if (rsp_ready_i) begin
      rsp_valid_q  <= 1'b0;
    end
  end

  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_port_o   = rsp_port_q;
  assign rsp_vc_o     = rsp_vc_q;
  assign rsp_nonmin_o = rsp_nonmin_q;
  assign rsp_mid_x_o  = rsp_mid_x_q;
  assign rsp_mid_y_o  = rsp_mid_y_q;

  p_rsp_after_accept_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> rsp_valid_o);

  p_hold_under_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_port_o) &&
      $stable(rsp_vc_o) && $stable(rsp_nonmin_o) && $stable(rsp_mid_x_o) && $stable(rsp_mid_y_o)));

  p_mid_excluded_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_new_i) |-> ({pick_y, pick_x} != {my_y_i, my_x_i} &&
      {pick_y, pick_x} != {req_dst_y_i, req_dst_x_i}));

  p_local_eject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && req_new_i && at_dst) |=>
      (int'(rsp_port_o) < CONC && rsp_vc_o == VC_TO_DST && !rsp_nonmin_o));

  p_hop_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (hops_min <= 2'd2 && (at_dst == (hops_min == 2'd0))));
endmodule

// File: tb/fbfly_route_unit_tb.sv
module fbfly_route_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  my_x, my_y, mid_x_in, mid_y_in, dst_x, dst_y, term;
  logic [35:0] occ;
  logic req_valid = 1'b0, req_new, req_vc, rsp_ready;
  logic req_ready, rsp_valid, rsp_vc, rsp_nonmin;
  logic [3:0] rsp_port;
  logic [1:0] rsp_mid_x, rsp_mid_y;

  int n_chk = 0, n_fail = 0;

  fbfly_route_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .my_x_i(my_x), .my_y_i(my_y), .occ_i(occ),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_new_i(req_new),
    .req_vc_i(req_vc), .req_mid_x_i(mid_x_in), .req_mid_y_i(mid_y_in),
    .req_dst_x_i(dst_x), .req_dst_y_i(dst_y), .req_dst_term_i(term),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_port_o(rsp_port),
    .rsp_vc_o(rsp_vc), .rsp_nonmin_o(rsp_nonmin), .rsp_mid_x_o(rsp_mid_x),
    .rsp_mid_y_o(rsp_mid_y)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int rank(input int t, input int own);
    return (t < own) ? t : t - 1;
  endfunction

  function automatic int port_to(input int fx, input int fy, input int tx, input int ty, input int tm);
    if (fx != tx) return 4 + rank(tx, fx);
    if (fy != ty) return 7 + rank(ty, fy);
    return tm;
  endfunction

  function automatic int hops(input int fx, input int fy, input int tx, input int ty);
    return int'(fx != tx) + int'(fy != ty);
  endfunction

  function automatic int occ_of(input int p);
    if (p < 4) return 0;
    return int'(occ[(p-4)*6 +: 6]);
  endfunction

  // one request, sampled at the negedge after the accepting edge
  task automatic issue(input logic nw, input logic vc, input int mx, input int my_,
                       input int dx, input int dy, input int tm);
    @(negedge clk);
    req_new = nw; req_vc = vc; mid_x_in = 2'(mx); mid_y_in = 2'(my_);
    dst_x = 2'(dx); dst_y = 2'(dy); term = 2'(tm);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 rsp_valid after accept", int'(rsp_valid), 1);
  endtask

  task automatic check_new(input int dx, input int dy, input int tm);
    int mx, my_, pm, hm, pn, hn, nm;
    issue(1'b1, 1'b0, 0, 0, dx, dy, tm);
    mx = int'(rsp_mid_x); my_ = int'(rsp_mid_y);
    if (dx == int'(my_x) && dy == int'(my_y)) begin
      chk("R7 local port", int'(rsp_port), tm);
      chk("R7 local vc", int'(rsp_vc), 1);
      chk("R7 local nonmin", int'(rsp_nonmin), 0);
      return;
    end
    chk("R4 mid not self", int'(mx == int'(my_x) && my_ == int'(my_y)), 0);
    chk("R4 mid not dst", int'(mx == dx && my_ == dy), 0);
    pm = port_to(my_x, my_y, dx, dy, tm);
    hm = hops(my_x, my_y, dx, dy);
    pn = port_to(my_x, my_y, mx, my_, tm);
    hn = hops(my_x, my_y, mx, my_) + hops(mx, my_, dx, dy);
    nm = int'(occ_of(pm) * hm > occ_of(pn) * hn);
    chk("R3 nonmin choice", int'(rsp_nonmin), nm);
    chk("R1 R2 port", int'(rsp_port), nm ? pn : pm);
    chk("R5 vc", int'(rsp_vc), nm ? 0 : 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    my_x = 2'd1; my_y = 2'd2; occ = '0; rsp_ready = 1'b1;
    req_new = 1'b1; req_vc = 1'b0; mid_x_in = '0; mid_y_in = '0;
    dst_x = '0; dst_y = '0; term = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 reset rsp_valid", int'(rsp_valid), 0);
    chk("R10 reset req_ready", int'(req_ready), 1);

    // R1 R2 directed minimal routes with idle links
    issue(1'b1, 1'b0, 0, 0, 3, 2, 0);
    chk("R1 row port up", int'(rsp_port), 6);
    issue(1'b1, 1'b0, 0, 0, 0, 2, 0);
    chk("R1 row port low", int'(rsp_port), 4);
    issue(1'b1, 1'b0, 0, 0, 1, 0, 0);
    chk("R1 col port low", int'(rsp_port), 7);
    issue(1'b1, 1'b0, 0, 0, 1, 3, 0);
    chk("R1 col port up", int'(rsp_port), 9);
    issue(1'b1, 1'b0, 0, 0, 2, 0, 0);
    chk("R2 x first", int'(rsp_port), 5);
    chk("R5 idle minimal vc", int'(rsp_vc), 1);

    // R7 local under load
    occ = '1;
    check_new(1, 2, 3);
    // R3 equal costs stay minimal (all ports equal, h_non >= h_min)
    occ = {6{6'd5}};
    check_new(3, 3, 1);
    chk("R3 tie minimal", int'(rsp_nonmin), 0);
    // R3 congested minimal first hop
    occ = '0; occ[2*6 +: 6] = 6'd40;
    for (int i = 0; i < 8; i++) check_new(3, 0, 2);

    // R6 transit cases
    issue(1'b0, 1'b0, 1, 2, 3, 0, 1);
    chk("R6 at mid port", int'(rsp_port), 6);
    chk("R6 at mid vc", int'(rsp_vc), 1);
    chk("R6 at mid nonmin", int'(rsp_nonmin), 0);
    issue(1'b0, 1'b0, 1, 0, 3, 3, 1);
    chk("R6 toward mid port", int'(rsp_port), 7);
    chk("R6 toward mid vc", int'(rsp_vc), 0);
    chk("R6 mid echo", int'({rsp_mid_y, rsp_mid_x}), 4'b0001);
    issue(1'b0, 1'b1, 3, 3, 1, 2, 2);
    chk("R6 vc1 eject", int'(rsp_port), 2);
    chk("R6 vc1 stays", int'(rsp_vc), 1);

    // R9 stall
    @(negedge clk);
    rsp_ready = 1'b0;
    issue(1'b1, 1'b0, 0, 0, 0, 2, 0);
    chk("R9 ready low", int'(req_ready), 0);
    req_valid = 1'b1; dst_x = 2'd3;
    repeat (3) @(negedge clk);
    chk("R9 held valid", int'(rsp_valid), 1);
    chk("R9 held port", int'(rsp_port), 4);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 drained", int'(rsp_valid), 0);

    // random mix
    for (int i = 0; i < 300; i++) begin
      my_x = 2'($urandom); my_y = 2'($urandom);
      occ = {$urandom, $urandom} & 36'hF_FFFF_FFFF;
      check_new(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule